// File: doc/BRIEF.md
# PRBS7 Link Self-Test Checker

This block sits behind a deserializer and judges an at-speed self-test of the serial link. For as long as the self-test enable level is high, it receives one recovered 24-bit payload word per clock, qualified by a valid strobe. It takes its starting point from the first valid word. From then on it predicts each following word of a seven-stage pseudo-random sequence and compares the received word with that prediction bit by bit.

While a test is running, the block drives a blanking control that forces the normal parallel outputs to idle. Its pass line dips low for half a clock for each payload that arrived with errors, so an observer can count the dips to get an error rate. A registered per-payload error flag and a saturating count of errored payloads are also available for debug. When the enable level drops, the pass line stops pulsing and holds the overall verdict. It keeps that verdict until another test begins or the block is powered down through its reset. The length of a test is simply the length of the enable pulse.

Top module: `prbs7_selftest_chk`

## Requirements
- R1: The expected stream follows x^7 + x^6 + 1: each stream bit equals the XOR of the bits six and seven positions earlier. Bit 23 of a word is the earliest bit in time and bit 0 the latest, and the stream runs on without a break from one valid word to the next.
- R2: The first valid payload accepted at or after the rising edge of `test_en` is not compared. Its seven latest bits (bits 6 down to 0, bit 6 the oldest) become the predictor state.
- R3: A compared payload counts as errored when between 1 and 24 of its bits differ from the prediction. `err_flag_o` is high for exactly the cycle after an errored payload and low after a clean payload or a cycle without a payload.
- R4: While a test is active, `pass_o` is low during the low half of the clock in the cycle after each errored payload. It is high at every other time in that test.
- R5: `err_cnt_o` goes up by one for each errored payload and is cleared in the cycle after `test_en` rises.
- R6: `err_cnt_o` saturates at its all-ones value (65535) and does not wrap.
- R7: From the cycle after `test_en` falls, `pass_o` holds 1 if the test saw no errored payload and 0 otherwise. It keeps this value until a new test starts or reset is applied, and it reads 1 while a new test is running without errors.
- R8: `blank_o` is high from the cycle after `test_en` rises to the cycle after it falls, and low at all other times.
- R9: Words with `pay_valid` low, and any words presented while `test_en` is low, change neither the counter, the flag, the verdict nor the predictor.
- R10: Reset (power-down) forces `pass_o` to 1, `blank_o` to 0, `err_flag_o` to 0 and `err_cnt_o` to 0.
- R11: After the seed word, the prediction advances from its own state on every valid payload. A corrupted payload therefore does not disturb the prediction for the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-down) |
| test_en | input | 1 | Self-test enable level; its high time sets the test duration |
| pay_valid | input | 1 | Payload word valid strobe |
| pay_data | input | 24 | Deserialized payload word, bit 23 earliest |
| pass_o | output | 1 | Per-error low pulses while testing, held verdict afterwards |
| blank_o | output | 1 | Forces the normal parallel outputs idle during a test |
| err_flag_o | output | 1 | Registered flag, high the cycle after an errored payload |
| err_cnt_o | output | 16 | Saturating count of errored payloads |

## Verification
A predictor state that has lost step with the incoming stream shows up within one payload. `err_flag_o` rises in the next cycle and `pass_o` dips during the low half of that same cycle, and because the predictor runs freely, every later payload of the test is flagged as well. A phase register that is wrong shows in `blank_o` one cycle after the enable edge. A verdict bit or an error-memory bit that is wrong becomes visible at the falling enable edge, when `pass_o` fails to match whether `err_cnt_o` is zero. A counter that wraps or is not cleared is seen directly at `err_cnt_o` at the end of a run.

// File: rtl/prbs7_chk_pkg.sv
package prbs7_chk_pkg;

    localparam int PRBS_LEN = 7;
    localparam int PRBS_TAP = 6;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEED = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e                phase;
        logic [PRBS_LEN-1:0]   lfsr;
        logic                  err_flag;
        logic                  any_err;
        logic                  result;
    } chk_state_t;

endpackage

// File: rtl/prbs7_word_pred.sv
// Predicts one payload word of the PRBS stream from the last PRBS_LEN bits
// seen, bit WORD_W-1 first in time; also returns the state for the next word.
module prbs7_word_pred
    import prbs7_chk_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic [PRBS_LEN-1:0] state_i,
    output logic [WORD_W-1:0]   word_o,
    output logic [PRBS_LEN-1:0] next_o
);

    logic [PRBS_LEN-1:0] hist;
    logic                nbit;

    always_comb begin
        hist   = state_i;
        nbit   = 1'b0;
        word_o = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            // hist[PRBS_LEN-1] is seven bits back, hist[PRBS_TAP-1] six back
            nbit      = hist[PRBS_LEN-1] ^ hist[PRBS_TAP-1];
            word_o[i] = nbit;
            hist      = {hist[PRBS_LEN-2:0], nbit};
        end
        next_o = hist;
    end

endmodule

// File: rtl/prbs7_mismatch.sv
// Counts differing bits between a received and an expected word.
module prbs7_mismatch #(
    parameter int WORD_W = 24,
    localparam int MISS_W = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] rx_i,
    input  logic [WORD_W-1:0] exp_i,
    output logic [MISS_W-1:0] miss_o,
    output logic              err_o
);

    logic [WORD_W-1:0] diff;

    always_comb begin
        diff   = rx_i ^ exp_i;
        miss_o = '0;
        for (int i = 0; i < WORD_W; i++) begin
            miss_o = miss_o + MISS_W'(diff[i]);
        end
        err_o = (miss_o != '0) && (miss_o <= MISS_W'(WORD_W));
    end

endmodule

// File: rtl/prbs7_sat_cnt.sv
// Saturating event counter with synchronous clear.
module prbs7_sat_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != {CNT_W{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/prbs7_selftest_chk.sv
// Link self-test checker: seeds from the first payload, predicts the rest,
// pulses pass low per errored payload and holds the verdict after the test.
module prbs7_selftest_chk
    import prbs7_chk_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              pay_valid,
    input  logic [WORD_W-1:0] pay_data,
    output logic              pass_o,
    output logic              blank_o,
    output logic              err_flag_o,
    output logic [CNT_W-1:0]  err_cnt_o
);

    localparam int MISS_W = $clog2(WORD_W + 1);

    chk_state_t          st_d, st_q;
    logic [WORD_W-1:0]   exp_word;
    logic [PRBS_LEN-1:0] pred_next;
    logic [MISS_W-1:0]   miss_cnt;
    logic                word_err;
    logic                cnt_clr;
    logic                cnt_inc;
    logic                start_evt;
    logic                stop_evt;

    prbs7_word_pred #(.WORD_W(WORD_W)) u_pred (
        .state_i (st_q.lfsr),
        .word_o  (exp_word),
        .next_o  (pred_next)
    );

    prbs7_mismatch #(.WORD_W(WORD_W)) u_miss (
        .rx_i   (pay_data),
        .exp_i  (exp_word),
        .miss_o (miss_cnt),
        .err_o  (word_err)
    );

    prbs7_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (err_cnt_o)
    );

    always_comb begin
        st_d          = st_q;
        st_d.err_flag = 1'b0;
        cnt_clr       = 1'b0;
        cnt_inc       = 1'b0;
        start_evt     = test_en && (st_q.phase == PH_IDLE);
        stop_evt      = !test_en && (st_q.phase != PH_IDLE);

        if (start_evt) begin
            st_d.result  = 1'b1;
            st_d.any_err = 1'b0;
            cnt_clr      = 1'b1;
            if (pay_valid) begin
                st_d.lfsr  = pay_data[PRBS_LEN-1:0];
                st_d.phase = PH_RUN;
            end else begin
                st_d.phase = PH_SEED;
            end
        end else if (stop_evt) begin
            st_d.phase  = PH_IDLE;
            st_d.result = !st_q.any_err;
        end else if (st_q.phase == PH_SEED) begin
            if (pay_valid) begin
                st_d.lfsr  = pay_data[PRBS_LEN-1:0];
                st_d.phase = PH_RUN;
            end
        end else if (st_q.phase == PH_RUN) begin
            if (pay_valid) begin
                st_d.lfsr     = pred_next;
                st_d.err_flag = word_err;
                if (word_err) begin
                    st_d.any_err = 1'b1;
                    cnt_inc      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase    <= PH_IDLE;
            st_q.lfsr     <= '0;
            st_q.err_flag <= 1'b0;
            st_q.any_err  <= 1'b0;
            st_q.result   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // During a test the flag is gated onto the low half of the clock.
    assign pass_o     = (st_q.phase != PH_IDLE) ? !(st_q.err_flag && !clk) : st_q.result;
    assign blank_o    = (st_q.phase != PH_IDLE);
    assign err_flag_o = st_q.err_flag;

endmodule

// File: rtl/prbs7_selftest_sva.sv
module prbs7_selftest_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             test_en,
    input logic             pass_o,
    input logic             blank_o,
    input logic             err_flag_o,
    input logic [CNT_W-1:0] err_cnt_o
);

    assert_blank_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_en) |=> blank_o);

    assert_blank_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> !blank_o);

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_o && $past(blank_o) && err_flag_o && ($past(err_cnt_o) != {CNT_W{1'b1}}))
        |-> (err_cnt_o == $past(err_cnt_o) + 1'b1));

    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_o && $past(blank_o) && !err_flag_o) |-> $stable(err_cnt_o));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_o && $past(blank_o) && ($past(err_cnt_o) == {CNT_W{1'b1}}))
        |-> (err_cnt_o == {CNT_W{1'b1}}));

    assert_idle_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && !blank_o) |=> $stable(err_cnt_o));

    assert_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_o |-> (pass_o == (err_cnt_o == '0)));

    assert_flag_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_o |-> !err_flag_o);

endmodule

bind prbs7_selftest_chk prbs7_selftest_sva #(.CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_en    (test_en),
    .pass_o     (pass_o),
    .blank_o    (blank_o),
    .err_flag_o (err_flag_o),
    .err_cnt_o  (err_cnt_o)
);

// File: tb/prbs7_selftest_chk_tb.sv
module prbs7_selftest_chk_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_en = 1'b0;
    logic        pay_valid = 1'b0;
    logic [23:0] pay_data = '0;
    logic        pass_o;
    logic        blank_o;
    logic        err_flag_o;
    logic [15:0] err_cnt_o;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    bit finished = 1'b0;
    logic [6:0] gen;

    always #5 clk = ~clk;

    prbs7_selftest_chk u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_en    (test_en),
        .pay_valid  (pay_valid),
        .pay_data   (pay_data),
        .pass_o     (pass_o),
        .blank_o    (blank_o),
        .err_flag_o (err_flag_o),
        .err_cnt_o  (err_cnt_o)
    );

    // Error pulses are dips of pass_o that begin on a falling clock edge.
    always @(negedge pass_o) begin
        if (clk === 1'b0 && rst_n === 1'b1) pulses++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    // Stream model: next bit is XOR of bits 6 and 7 back; bit 23 goes first.
    function automatic logic [23:0] next_word();
        logic [23:0] w;
        logic b;
        for (int k = 23; k >= 0; k--) begin
            b = gen[6] ^ gen[5];
            w[k] = b;
            gen = {gen[5:0], b};
        end
        return w;
    endfunction

    task automatic send(input logic [23:0] w, input logic v);
        pay_data = w;
        pay_valid = v;
        cyc();
        pay_valid = 1'b0;
    endtask

    task automatic start_test();
        test_en = 1'b1;
        pay_valid = 1'b0;
        cyc();
        chk(blank_o == 1'b1, "R8 blank after start", blank_o, 1);
        chk(err_cnt_o == 0, "R5 count cleared at start", err_cnt_o, 0);
        chk(pass_o == 1'b1, "R7 pass high in new test", pass_o, 1);
        pulses = 0;
    endtask

    task automatic stop_test();
        test_en = 1'b0;
        pay_valid = 1'b0;
        cyc();
        chk(blank_o == 1'b0, "R8 blank cleared after stop", blank_o, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        test_en = 1'b0;
        pay_valid = 1'b0;
        cyc();
        cyc();
        rst_n = 1'b1;
        cyc();
        chk(pass_o == 1'b1, "R10 pass after reset", pass_o, 1);
        chk(blank_o == 1'b0, "R10 blank after reset", blank_o, 0);
        chk(err_flag_o == 1'b0, "R10 flag after reset", err_flag_o, 0);
        chk(err_cnt_o == 0, "R10 count after reset", err_cnt_o, 0);
    endtask

    task automatic t_clean();
        gen = 7'h5A;
        start_test();
        for (int i = 0; i < 30; i++) send(next_word(), 1'b1);
        chk(err_flag_o == 1'b0, "R1 no flag on clean stream", err_flag_o, 0);
        stop_test();
        chk(pulses == 0, "R4 no pulses on clean stream", pulses, 0);
        chk(err_cnt_o == 0, "R1 count zero on clean stream", err_cnt_o, 0);
        chk(pass_o == 1'b1, "R7 verdict pass", pass_o, 1);
    endtask

    task automatic t_one_bit();
        logic [23:0] w;
        gen = 7'h11;
        start_test();
        for (int i = 0; i < 40; i++) begin
            w = next_word();
            if (i == 10) begin
                send(w ^ 24'h000001, 1'b1);
                chk(err_flag_o == 1'b1, "R3 flag after 1-bit error", err_flag_o, 1);
                chk(pass_o == 1'b1, "R4 pass high in high clock half", pass_o, 1);
                #5;
                chk(pass_o == 1'b0, "R4 pass low in low clock half", pass_o, 0);
            end else if (i == 11) begin
                send(w, 1'b1);
                chk(err_flag_o == 1'b0, "R11 next word clean after error", err_flag_o, 0);
            end else begin
                send(w, 1'b1);
            end
        end
        stop_test();
        chk(pulses == 1, "R4 one pulse", pulses, 1);
        chk(err_cnt_o == 1, "R5 count one", err_cnt_o, 1);
        chk(pass_o == 1'b0, "R7 verdict fail", pass_o, 0);
        for (int i = 0; i < 5; i++) cyc();
        chk(pass_o == 1'b0, "R7 verdict held", pass_o, 0);
    endtask

    task automatic t_gaps();
        gen = 7'h3C;
        start_test();
        for (int i = 0; i < 20; i++) begin
            send(next_word(), 1'b1);
            send(24'hDEAD01 ^ 24'(i), 1'b0);
        end
        chk(err_flag_o == 1'b0, "R9 no flag across gaps", err_flag_o, 0);
        stop_test();
        chk(err_cnt_o == 0, "R9 invalid words ignored", err_cnt_o, 0);
        chk(pass_o == 1'b1, "R7 new test clears fail", pass_o, 1);
        for (int i = 0; i < 6; i++) send(24'h123456 + 24'(i), 1'b1);
        chk(err_cnt_o == 0, "R9 words ignored while disabled", err_cnt_o, 0);
        chk(pass_o == 1'b1, "R9 verdict unchanged while disabled", pass_o, 1);
        chk(blank_o == 1'b0, "R9 no blank while disabled", blank_o, 0);
    endtask

    task automatic t_full();
        logic [23:0] w;
        gen = 7'h7F;
        start_test();
        for (int i = 0; i < 25; i++) begin
            w = next_word();
            if (i == 5 || i == 6 || i == 15) send(~w, 1'b1);
            else send(w, 1'b1);
        end
        stop_test();
        chk(pulses == 3, "R3 three 24-bit errored payloads pulse", pulses, 3);
        chk(err_cnt_o == 3, "R3 count of 24-bit errors", err_cnt_o, 3);
        chk(pass_o == 1'b0, "R7 verdict fail after 24-bit errors", pass_o, 0);
    endtask

    task automatic t_seed();
        logic [23:0] w;
        test_en = 1'b1;
        w = 24'hF0F0F3;
        send(w, 1'b1);
        pulses = 0;
        chk(blank_o == 1'b1, "R8 blank when seeded on start edge", blank_o, 1);
        gen = w[6:0];
        for (int i = 0; i < 15; i++) send(next_word(), 1'b1);
        stop_test();
        chk(err_cnt_o == 0, "R2 seed word not compared", err_cnt_o, 0);
        chk(pass_o == 1'b1, "R2 verdict after arbitrary seed", pass_o, 1);
    endtask

    task automatic t_sat();
        gen = 7'h21;
        start_test();
        send(next_word(), 1'b1);
        for (int i = 0; i < 65540; i++) send(~next_word(), 1'b1);
        stop_test();
        chk(err_cnt_o == 16'hFFFF, "R6 count saturates", err_cnt_o, 65535);
        chk(pulses == 65540, "R4 pulse per errored payload", pulses, 65540);
        chk(pass_o == 1'b0, "R7 verdict fail after long run", pass_o, 0);
    endtask

    initial begin
        do_reset();
        t_clean();
        t_one_bit();
        t_gaps();
        t_full();
        t_seed();
        t_sat();
        do_reset();
        chk(pass_o == 1'b1, "R10 power-down clears held fail", pass_o, 1);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(10 * 190000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule